// File: doc/BRIEF.md
# Waveform Sample Capture Unit

This block sits beside a two-channel measurement sample path and lets a small 8-bit processor look at the raw waveforms. Every cycle that the sample-valid strobe is high, a signed 24-bit current sample and a signed 24-bit voltage sample arrive. A rate divider picks one input event out of every 1, 2, 4 or 8, as the 2-bit rate selector sets. Each picked event updates a pair of live sample holders, one for each readable slot, and marks a sticky status flag. When the interrupt enable is set, the flag drives a pending-interrupt output.

Software reads bytes over a byte-addressed read port. A read of a slot's high byte copies the live holders of both slots into a snapshot. That high-byte read returns the snapshot value, and so do all later reads of the middle and low bytes. All three bytes of one sample therefore always come from the same event. The capture unit only watches the sample stream. It never stalls the stream and has no ready signal.

Top module: `wfcap_top`

## Requirements
- R1: After synchronous reset (`rst`=1), `wav_flag` and `irq` are 0, every readable byte returns 0x00, and the divider count is zero. The first sample event after reset is therefore always kept.
- R2: The rate selector `rate_sel` has encoding 00=every event, 01=one in 2, 10=one in 4, 11=one in 8. The kept events are the 1st, (2^N+1)th and so on after reset, counting `smp_vld` cycles.
- R3: Only kept events update the live holders and set `wav_flag`. Dropped events leave both unchanged.
- R4: `wav_flag` rises one cycle after a kept event. It stays set until a cycle with `flag_clr`=1 and no kept event.
- R5: When `flag_clr` and a kept event fall in the same cycle, `wav_flag` is 1 in the next cycle.
- R6: `irq` equals `wav_flag` AND `irq_en`. It is combinational from the registered flag.
- R7: Each slot has a source select. `slotN_src`=0 chooses the current sample and 1 chooses the voltage sample.
- R8: The read address map is: 0=slot0 low, 1=slot0 mid, 2=slot0 high, 3=slot1 low, 4=slot1 mid, 5=slot1 high. Other addresses read 0x00. A read of address 2 or 5 (`rd_en`=1) loads the snapshot of both slots from the live holders. `rd_data` is registered and valid the cycle after `rd_en`.
- R9: Low and mid bytes return the snapshot. They do not return the live holders, so new kept events after a high-byte read do not change them.
- R10: Samples are two's complement 24-bit. A byte read returns bits [7:0], [15:8] or [23:16] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample event strobe |
| smp_cur | input | 24 | Current channel sample |
| smp_vol | input | 24 | Voltage channel sample |
| rate_sel | input | 2 | Decimation selector |
| slot0_src | input | 1 | Slot 0 source (0 current, 1 voltage) |
| slot1_src | input | 1 | Slot 1 source |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Status clear |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Byte address |
| rd_data | output | 8 | Registered read data |
| wav_flag | output | 1 | Sticky new-sample status |
| irq | output | 1 | Pending interrupt |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a kept sample event and a software status clear. The second pair is a kept event and a high-byte snapshot read. The bench drives `flag_clr` in the same cycle as a kept event and expects the flag to stay set. It then clears again in a quiet cycle and expects the flag to drop. It also issues a high-byte read in the same cycle as a new kept event and checks that the snapshot holds the earlier live value. A later low-byte read must still match that earlier value after more events arrive.

// File: rtl/wfcap_pkg.sv
package wfcap_pkg;
    localparam int SMP_W   = 24;
    localparam int RATE_W  = 2;
    localparam int NSLOT   = 2;
    localparam int BYTES   = SMP_W / 8;
    localparam int ADDR_W  = 3;
    localparam int DIV_W   = (1 << RATE_W) - 1;

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef enum logic [RATE_W-1:0] {
        RATE_FULL = 2'd0,
        RATE_HALF = 2'd1,
        RATE_QTR  = 2'd2,
        RATE_OCT  = 2'd3
    } rate_e;

    typedef struct packed {
        logic [ADDR_W-1:0] slot;
        logic [1:0]        byte_idx;
        logic              valid;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t d;
        d.valid    = (int'(a) < NSLOT * BYTES);
        d.slot     = ADDR_W'(int'(a) / BYTES);
        d.byte_idx = 2'(int'(a) % BYTES);
        return d;
    endfunction

    function automatic logic [7:0] pick_byte(input smp_t s, input logic [1:0] idx);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 0; i < BYTES; i++)
            if (idx == 2'(i)) r = s[i*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/wfcap_decim.sv
module wfcap_decim
    import wfcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              keep
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DIV_W; i++)
            if (i < int'(rate_sel)) mask[i] = 1'b1;
    end

    assign keep = smp_vld && ((cnt & mask) == '0);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (smp_vld) cnt <= cnt + 1'b1;
    end

    a_r2_full_keeps_all: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && rate_sel == RATE_FULL) |-> keep);
    a_r3_no_keep_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |-> !keep);
endmodule

// File: rtl/wfcap_status.sv
module wfcap_status (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set_evt && clr) |=> flag);
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_evt) |=> !flag);
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/wfcap_regs.sv
module wfcap_regs
    import wfcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              keep,
    input  smp_t              smp_cur,
    input  smp_t              smp_vol,
    input  logic [NSLOT-1:0]  slot_src,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    smp_t live [NSLOT];
    smp_t snap [NSLOT];
    addr_dec_t dec;
    logic hi_rd;

    assign dec   = decode_addr(rd_addr);
    assign hi_rd = rd_en && dec.valid && (dec.byte_idx == 2'(BYTES-1));

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                live[g] <= '0;
                snap[g] <= '0;
            end else begin
                if (keep)  live[g] <= slot_src[g] ? smp_vol : smp_cur;
                if (hi_rd) snap[g] <= live[g];
            end
        end

        a_r3_live_hold: assert property (@(posedge clk) disable iff (rst)
            !keep |=> $stable(live[g]));
        a_r9_snap_hold: assert property (@(posedge clk) disable iff (rst)
            !hi_rd |=> $stable(snap[g]));
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= 8'h00;
        else if (rd_en) begin
            if (!dec.valid)  rd_data <= 8'h00;
            else if (hi_rd)  rd_data <= pick_byte(live[dec.slot[0]], dec.byte_idx);
            else             rd_data <= pick_byte(snap[dec.slot[0]], dec.byte_idx);
        end
    end
endmodule

// File: rtl/wfcap_top.sv
module wfcap_top
    import wfcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_vld,
    input  logic [23:0] smp_cur,
    input  logic [23:0] smp_vol,
    input  logic [1:0]  rate_sel,
    input  logic        slot0_src,
    input  logic        slot1_src,
    input  logic        irq_en,
    input  logic        flag_clr,
    input  logic        rd_en,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        wav_flag,
    output logic        irq
);
    logic keep;

    wfcap_decim u_decim (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .rate_sel(rate_sel), .keep(keep)
    );

    wfcap_status u_status (
        .clk(clk), .rst(rst), .set_evt(keep), .clr(flag_clr),
        .irq_en(irq_en), .flag(wav_flag), .irq(irq)
    );

    wfcap_regs u_regs (
        .clk(clk), .rst(rst), .keep(keep), .smp_cur(smp_cur), .smp_vol(smp_vol),
        .slot_src({slot1_src, slot0_src}), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    a_r6_irq_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> (wav_flag && irq_en));
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!wav_flag && rd_data == 8'h00));
endmodule

// File: tb/wfcap_top_tb_top.sv
module wfcap_top_tb_top;
    logic clk = 0, rst = 1;
    logic smp_vld = 0;
    logic [23:0] smp_cur = 0, smp_vol = 0;
    logic [1:0] rate_sel = 0;
    logic slot0_src = 0, slot1_src = 1, irq_en = 0, flag_clr = 0, rd_en = 0;
    logic [2:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic wav_flag, irq;
    int total = 0, bad = 0;

    always #2 clk = ~clk;

    wfcap_top dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(); @(posedge clk); #1; endtask

    task automatic do_reset();
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic push(input logic [23:0] c, input logic [23:0] v);
        smp_vld = 1; smp_cur = c; smp_vol = v; step(); smp_vld = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_en = 1; rd_addr = a; step(); rd_en = 0; d = rd_data;
    endtask

    task automatic clr_flag();
        flag_clr = 1; step(); flag_clr = 0;
    endtask

    task automatic read_word(input int slot, output logic [23:0] w);
        logic [7:0] h, m, l;
        rd(3'(slot*3+2), h); rd(3'(slot*3+1), m); rd(3'(slot*3), l);
        w = {h, m, l};
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        chk("R1 flag", wav_flag, 0);
        chk("R1 irq", irq, 0);
        for (int a = 0; a < 6; a++) begin rd(3'(a), d); chk("R1 byte", d, 0); end
    endtask

    task automatic t_map();
        logic [23:0] w;
        logic [7:0] d;
        do_reset();
        push(24'hD70B12, 24'h28F5A3);
        chk("R4 flag rise", wav_flag, 1);
        read_word(0, w); chk("R7 R10 slot0 cur", w, 24'hD70B12);
        read_word(1, w); chk("R7 R8 slot1 vol", w, 24'h28F5A3);
        rd(3'd6, d); chk("R8 unmapped", d, 0);
        slot0_src = 1; push(24'h111111, 24'h800001); slot0_src = 0;
        read_word(0, w); chk("R7 slot0 vol", w, 24'h800001);
    endtask

    task automatic t_irq();
        do_reset();
        push(24'h1, 24'h2);
        chk("R6 irq off", irq, 0);
        irq_en = 1; #0; chk("R6 irq on", irq, 1);
        step(); chk("R4 sticky", wav_flag, 1);
        clr_flag(); chk("R4 cleared", wav_flag, 0);
        chk("R6 irq follows", irq, 0);
        irq_en = 0;
    endtask

    task automatic t_clr_collide();
        do_reset();
        smp_vld = 1; smp_cur = 24'h5; flag_clr = 1; step();
        smp_vld = 0; flag_clr = 0;
        chk("R5 set wins", wav_flag, 1);
        clr_flag(); chk("R5 later clear", wav_flag, 0);
    endtask

    task automatic t_rate(input logic [1:0] r);
        logic [23:0] w;
        int per;
        per = 1 << r;
        do_reset();
        rate_sel = r;
        for (int i = 0; i < 2*per; i++) begin
            push(24'(100 + i), 24'h0);
            if (i == 0) chk("R2 first kept", wav_flag, 1);
            clr_flag();
            read_word(0, w);
            chk("R2 R3 held value", w, 24'(100 + ((i / per) * per)));
        end
        rate_sel = 0;
    endtask

    task automatic t_drop_no_flag();
        do_reset();
        rate_sel = 2'b11;
        push(24'h1, 0); clr_flag();
        push(24'h2, 0);
        chk("R3 dropped no flag", wav_flag, 0);
        rate_sel = 0;
    endtask

    task automatic t_snapshot();
        logic [7:0] d;
        do_reset();
        push(24'hABCDEF, 24'h0);
        smp_vld = 1; smp_cur = 24'h123456; rd_en = 1; rd_addr = 3'd2; step();
        smp_vld = 0; rd_en = 0;
        chk("R8 hi old", rd_data, 8'hAB);
        push(24'h777777, 0);
        rd(3'd1, d); chk("R9 mid snap", d, 8'hCD);
        rd(3'd0, d); chk("R9 low snap", d, 8'hEF);
        rd(3'd2, d); chk("R8 new hi", d, 8'h77);
        rd(3'd0, d); chk("R9 new low", d, 8'h77);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_map();
                t_irq();
                t_clr_collide();
                for (int r = 0; r < 4; r++) t_rate(2'(r));
                t_drop_no_flag();
                t_snapshot();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog act=timeout exp=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule